// File: doc/BRIEF.md
# Bit-Serial PHY Management Responder

This block stands in for the PHY end of a two-wire management link. A host that has no real management pins drives the link by writing a 32-bit control word. Each write whose bits form the "clock with data out" pattern hands one serial bit to a frame decoder. Each write whose bits form the "clock with data in" pattern moves one bit from an internal output shift register into a status bit of the stored control word, where the host reads it back.

The decoder accepts read and write frames. It holds a bank of 16-bit registers, selected by a 5-bit PHY number and a 5-bit register number. Register number 1 is never taken from the bank on a read: it reports a link-up flag that comes from an input pin. Read data is placed in the output shift register so that the host's first clocked-in bit is a throwaway zero, and the 16 data bits follow, most significant first.

Top module: `mgmt_phy_responder`

## Requirements
- R1: After synchronous reset the control word reads 0x00000000, and every register reads back 0x0000 until it has been written.
- R2: Bit 17 of each control-word write is ignored when the write is classified. The remaining bits must equal exactly bits {18,16,14} for a read strobe, or exactly bits {16,13} for a write strobe. Any other write is stored but neither advances the decoder nor shifts out a bit.
- R3: When the decoder is idle, a serial 1 leaves it idle and a serial 0 arms it. Once armed, a 1 completes the start and a 0 returns the decoder to idle.
- R4: After the start, the serial pair 1,0 opens a read frame and the pair 0,1 opens a write frame. The pairs 1,1 and 0,0 return the decoder to idle, and the frame has no effect.
- R5: The opcode is followed by a 5-bit PHY number and then a 5-bit register number, both most significant bit first. All 32×32 registers are independent.
- R6: In a write frame, the address is followed by two turnaround bits. If they are not 1 then 0, the frame is dropped. When they are, 16 data bits follow, most significant first, and the last one commits the value to the addressed register.
- R7: When the last address bit of a read frame arrives, the addressed value is loaded into a 32-bit shift register at bit offset 15. The first read strobe after that yields 0, the next 16 read strobes yield the value MSB first, and later strobes yield 0.
- R8: A read of register number 1, at any PHY number, returns 0x0004 if link_up was high on the cycle of the last address bit, and 0x0000 if it was low. This holds even if that register has been written.
- R9: A read strobe stores the written word with bit 19 replaced by the bit shifted out. Every other write stores the written word unchanged. ctl_rdata shows the stored word one cycle after the write.
- R10: The fetched value enters the shift register on the cycle after the last address bit. A read strobe in that same cycle shifts out the dummy bit of the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control-word write enable, one write per cycle |
| ctl_wdata | input | 32 | Control word being written |
| link_up | input | 1 | Link state reported through register number 1 |
| ctl_rdata | output | 32 | Stored control word; bit 19 carries serial read data |

## Verification
Two operations can fall in the same cycle: loading a freshly fetched register value into the output shift register, and a read strobe that shifts a bit out. The bench provokes this by issuing a read strobe on the cycle directly after the strobe that carries the final address bit, with no idle cycle between them. It judges the result by requiring the same bit stream as a read with a gap: a leading zero, then exactly the 16 stored bits, with none lost or doubled.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
  localparam int CTL_W    = 32;
  localparam int SDO_BIT  = 17;  // host serial out, ignored by classifier
  localparam int SDI_BIT  = 19;  // serial in returned to host
  localparam logic [CTL_W-1:0] RD_PATTERN = (32'h1 << 18) | (32'h1 << 16) | (32'h1 << 14);
  localparam logic [CTL_W-1:0] WR_PATTERN = (32'h1 << 16) | (32'h1 << 13);

  typedef enum logic [3:0] {
    ST_IDLE, ST_ARMED, ST_SOF, ST_OP_RD, ST_OP_WR,
    ST_ADDR, ST_TA1, ST_TA2, ST_DATA
  } frame_state_t;
endpackage

// File: rtl/mgmt_strobe_decode.sv
module mgmt_strobe_decode
  import mgmt_pkg::*;
(
  input  logic             we,
  input  logic [CTL_W-1:0] wdata,
  output logic             rd_stb,
  output logic             wr_stb,
  output logic             ser_bit
);
  logic [CTL_W-1:0] masked;
  always_comb begin
    masked  = wdata & ~(CTL_W'(1) << SDO_BIT);
    rd_stb  = we && (masked == RD_PATTERN);
    wr_stb  = we && (masked == WR_PATTERN);
    ser_bit = wdata[SDO_BIT];
  end
endmodule

// File: rtl/mgmt_frame_fsm.sv
module mgmt_frame_fsm
  import mgmt_pkg::*;
#(
  parameter int PHY_AW = 5,
  parameter int REG_AW = 5,
  parameter int DW     = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bit_stb,
  input  logic                       bit_in,
  output logic                       rd_en,
  output logic                       wr_en,
  output logic [PHY_AW+REG_AW-1:0]   acc_addr,
  output logic [DW-1:0]              wr_data
);
  localparam int AW    = PHY_AW + REG_AW;
  localparam int MAXB  = (AW > DW) ? AW : DW;
  localparam int CNT_W = $clog2(MAXB);

  frame_state_t     state_q;
  logic [AW-1:0]    addr_q, addr_next;
  logic [DW-1:0]    data_q, data_next;
  logic [CNT_W-1:0] cnt_q;
  logic             is_wr_q;
  logic             addr_last, data_last;

  always_comb begin
    addr_next = {addr_q[AW-2:0], bit_in};
    data_next = {data_q[DW-2:0], bit_in};
    addr_last = (cnt_q == CNT_W'(AW - 1));
    data_last = (cnt_q == CNT_W'(DW - 1));
    rd_en     = bit_stb && (state_q == ST_ADDR) && addr_last && !is_wr_q;
    wr_en     = bit_stb && (state_q == ST_DATA) && data_last;
    acc_addr  = rd_en ? addr_next : addr_q;
    wr_data   = data_next;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      data_q  <= '0;
      cnt_q   <= '0;
      is_wr_q <= 1'b0;
    end else if (bit_stb) begin
      unique case (state_q)
        ST_IDLE: begin
          addr_q  <= '0;
          data_q  <= '0;
          cnt_q   <= '0;
          state_q <= bit_in ? ST_IDLE : ST_ARMED;
        end
        ST_ARMED: state_q <= bit_in ? ST_SOF : ST_IDLE;
        ST_SOF:   state_q <= bit_in ? ST_OP_RD : ST_OP_WR;
        ST_OP_RD: begin
          is_wr_q <= 1'b0;
          state_q <= bit_in ? ST_IDLE : ST_ADDR;
        end
        ST_OP_WR: begin
          is_wr_q <= 1'b1;
          state_q <= bit_in ? ST_ADDR : ST_IDLE;
        end
        ST_ADDR: begin
          addr_q <= addr_next;
          if (addr_last) begin
            cnt_q   <= '0;
            state_q <= is_wr_q ? ST_TA1 : ST_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_TA1: state_q <= bit_in ? ST_TA2 : ST_IDLE;
        ST_TA2: state_q <= bit_in ? ST_IDLE : ST_DATA;
        ST_DATA: begin
          data_q <= data_next;
          if (data_last) state_q <= ST_IDLE;
          else           cnt_q   <= cnt_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mgmt_reg_bank.sv
module mgmt_reg_bank #(
  parameter int AW         = 10,
  parameter int REG_AW     = 5,
  parameter int DW         = 16,
  parameter int STATUS_REG = 1,
  parameter int LINK_BIT   = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wr_data,
  input  logic          link_up,
  output logic          rd_load,
  output logic [DW-1:0] rd_word
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0]    mem [DEPTH];
  logic [DEPTH-1:0] written_q;
  logic [DW-1:0]    rd_q;
  logic             rd_written_q, rd_status_q, link_q, load_q;

  // Plain dual-use RAM without reset so it maps to block memory
  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= wr_data;
    if (rd_en) rd_q <= mem[addr];
  end

  // Per-entry written flags give the zero-after-reset view
  always_ff @(posedge clk) begin
    if (rst) begin
      written_q    <= '0;
      rd_written_q <= 1'b0;
      rd_status_q  <= 1'b0;
      link_q       <= 1'b0;
      load_q       <= 1'b0;
    end else begin
      if (wr_en) written_q[addr] <= 1'b1;
      load_q <= rd_en;
      if (rd_en) begin
        rd_written_q <= written_q[addr];
        rd_status_q  <= (addr[REG_AW-1:0] == REG_AW'(STATUS_REG));
        link_q       <= link_up;
      end
    end
  end

  always_comb begin
    rd_load = load_q;
    if (rd_status_q)       rd_word = link_q ? (DW'(1) << LINK_BIT) : '0;
    else if (rd_written_q) rd_word = rd_q;
    else                   rd_word = '0;
  end
endmodule

// File: rtl/mgmt_shift_out.sv
module mgmt_shift_out #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] load_word,
  input  logic          pop,
  output logic          pop_bit
);
  localparam int SW = 2 * DW;

  logic [SW-1:0] sh_q, loaded;

  always_comb begin
    loaded  = SW'(load_word) << (DW - 1);
    pop_bit = load ? loaded[SW-1] : sh_q[SW-1];
  end

  always_ff @(posedge clk) begin
    if (rst)       sh_q <= '0;
    else if (load) sh_q <= pop ? (loaded << 1) : loaded;
    else if (pop)  sh_q <= sh_q << 1;
  end
endmodule

// File: rtl/mgmt_phy_responder.sv
module mgmt_phy_responder
  import mgmt_pkg::*;
#(
  parameter int PHY_AW     = 5,
  parameter int REG_AW     = 5,
  parameter int DW         = 16,
  parameter int STATUS_REG = 1,
  parameter int LINK_BIT   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             link_up,
  output logic [CTL_W-1:0] ctl_rdata
);
  localparam int AW = PHY_AW + REG_AW;

  logic          rd_stb, wr_stb, ser_bit;
  logic          fsm_rd_en, fsm_wr_en;
  logic [AW-1:0] fsm_addr;
  logic [DW-1:0] fsm_wdata, bank_word;
  logic          bank_load, pop_bit;
  logic [CTL_W-1:0] ctl_q;

  mgmt_strobe_decode u_dec (
    .we(ctl_we), .wdata(ctl_wdata),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .ser_bit(ser_bit)
  );

  mgmt_frame_fsm #(.PHY_AW(PHY_AW), .REG_AW(REG_AW), .DW(DW)) u_fsm (
    .clk(clk), .rst(rst), .bit_stb(wr_stb), .bit_in(ser_bit),
    .rd_en(fsm_rd_en), .wr_en(fsm_wr_en), .acc_addr(fsm_addr), .wr_data(fsm_wdata)
  );

  mgmt_reg_bank #(.AW(AW), .REG_AW(REG_AW), .DW(DW),
                  .STATUS_REG(STATUS_REG), .LINK_BIT(LINK_BIT)) u_bank (
    .clk(clk), .rst(rst), .wr_en(fsm_wr_en), .rd_en(fsm_rd_en),
    .addr(fsm_addr), .wr_data(fsm_wdata), .link_up(link_up),
    .rd_load(bank_load), .rd_word(bank_word)
  );

  mgmt_shift_out #(.DW(DW)) u_shift (
    .clk(clk), .rst(rst), .load(bank_load), .load_word(bank_word),
    .pop(rd_stb), .pop_bit(pop_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) ctl_q <= '0;
    else if (ctl_we) begin
      ctl_q <= ctl_wdata;
      if (rd_stb) ctl_q[SDI_BIT] <= pop_bit;
    end
  end

  assign ctl_rdata = ctl_q;
endmodule

// File: rtl/mgmt_phy_responder_chk.sv
module mgmt_phy_responder_chk
  import mgmt_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             ctl_we,
  input logic [CTL_W-1:0] ctl_wdata,
  input logic [CTL_W-1:0] ctl_rdata,
  input logic             rd_en,
  input logic             wr_en,
  input logic             load
);
  logic [CTL_W-1:0] masked;
  logic is_rd, is_wr;
  always_comb begin
    masked = ctl_wdata & ~(CTL_W'(1) << SDO_BIT);
    is_rd  = ctl_we && (masked == RD_PATTERN);
    is_wr  = ctl_we && (masked == WR_PATTERN);
  end

  // R2
  plain_store_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_we && !is_rd) |=> (ctl_rdata == $past(ctl_wdata)));

  // R9
  pop_keeps_other_bits_chk: assert property (@(posedge clk) disable iff (rst)
    is_rd |=> ((ctl_rdata & ~(CTL_W'(1) << SDI_BIT)) == ($past(ctl_wdata) & ~(CTL_W'(1) << SDI_BIT))));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ctl_we |=> $stable(ctl_rdata));

  // R6
  commit_on_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> is_wr);

  // R7
  fetch_on_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> is_wr);

  // R4
  one_access_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rd_en, wr_en}));

  // R10
  load_follows_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> load);
endmodule

bind mgmt_phy_responder mgmt_phy_responder_chk u_chk (
  .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
  .ctl_rdata(ctl_rdata), .rd_en(fsm_rd_en), .wr_en(fsm_wr_en), .load(bank_load)
);

// File: tb/mgmt_phy_responder_bench.sv
module mgmt_phy_responder_bench;
  localparam logic [31:0] RDP = (32'h1 << 18) | (32'h1 << 16) | (32'h1 << 14);
  localparam logic [31:0] WRP = (32'h1 << 16) | (32'h1 << 13);

  // {write, link, phy[4:0], reg[4:0], data/expected[15:0]}
  localparam int NV = 12;
  localparam logic [27:0] VEC [NV] = '{
    {1'b1, 1'b0, 5'd3,  5'd5,  16'hA5C3},
    {1'b1, 1'b0, 5'd3,  5'd6,  16'h1234},
    {1'b0, 1'b0, 5'd3,  5'd5,  16'hA5C3},
    {1'b0, 1'b0, 5'd3,  5'd6,  16'h1234},
    {1'b0, 1'b0, 5'd7,  5'd5,  16'h0000},
    {1'b1, 1'b0, 5'd31, 5'd31, 16'h8001},
    {1'b0, 1'b0, 5'd31, 5'd31, 16'h8001},
    {1'b1, 1'b0, 5'd0,  5'd1,  16'hBEEF},
    {1'b0, 1'b1, 5'd0,  5'd1,  16'h0004},
    {1'b0, 1'b0, 5'd9,  5'd1,  16'h0000},
    {1'b1, 1'b0, 5'd3,  5'd5,  16'h0F0F},
    {1'b0, 1'b0, 5'd3,  5'd5,  16'h0F0F}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctl_we = 1'b0;
  logic [31:0] ctl_wdata = '0;
  logic link_up = 1'b0;
  logic [31:0] ctl_rdata;
  int n_chk = 0;
  int n_bad = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  mgmt_phy_responder u_mgmt_phy_responder (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .link_up(link_up), .ctl_rdata(ctl_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ctl_write(input logic [31:0] d);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = d;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic send_bit(input logic b);
    ctl_write(WRP | (32'(b) << 17));
  endtask

  task automatic pop(input logic with_sdo, output logic b);
    ctl_write(RDP | (32'(with_sdo) << 17));
    b = ctl_rdata[19];
  endtask

  task automatic send_hdr(input logic wr, input logic [4:0] phy, input logic [4:0] rg, input int nlast);
    send_bit(1); send_bit(1); send_bit(0); send_bit(1);
    send_bit(!wr); send_bit(wr);
    for (int i = 4; i >= 0; i--) send_bit(phy[i]);
    for (int i = 4; i >= nlast; i--) send_bit(rg[i]);
  endtask

  task automatic do_write(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] d);
    send_hdr(1'b1, phy, rg, 0);
    send_bit(1); send_bit(0);
    for (int i = 15; i >= 0; i--) send_bit(d[i]);
  endtask

  task automatic collect(input logic first, output logic dummy, output logic [15:0] v, output logic tail);
    logic b;
    dummy = first;
    for (int i = 15; i >= 0; i--) begin pop(i[0], b); v[i] = b; end
    pop(1'b0, tail);
  endtask

  task automatic do_read(input logic [4:0] phy, input logic [4:0] rg,
                         output logic dummy, output logic [15:0] v, output logic tail);
    logic b;
    send_hdr(1'b0, phy, rg, 0);
    pop(1'b1, b);
    collect(b, dummy, v, tail);
  endtask

  initial begin
    logic dm, tl, b;
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 control word after reset", ctl_rdata, 32'h0);
    do_read(5'd1, 5'd2, dm, v, tl);
    chk("R1 unwritten register", {16'h0, v}, 32'h0);

    // Table walk: R5 R6 R7 R8
    for (int k = 0; k < NV; k++) begin
      link_up = VEC[k][26];
      if (VEC[k][27]) begin
        do_write(VEC[k][25:21], VEC[k][20:16], VEC[k][15:0]);
      end else begin
        do_read(VEC[k][25:21], VEC[k][20:16], dm, v, tl);
        chk(VEC[k][20:16] == 5'd1 ? "R8 status register" : "R5 R7 read-back value",
            {16'h0, v}, {16'h0, VEC[k][15:0]});
        chk("R7 dummy bit", {31'h0, dm}, 32'h0);
        chk("R7 trailing zero", {31'h0, tl}, 32'h0);
      end
    end
    link_up = 1'b0;

    // R3: armed then 0 returns to idle, then a frame with no leading 1s
    send_bit(0); send_bit(0);
    send_bit(0); send_bit(1); send_bit(0); send_bit(1);
    for (int i = 4; i >= 0; i--) send_bit(5'd2 >> i);
    for (int i = 4; i >= 0; i--) send_bit(5'd9 >> i);
    send_bit(1); send_bit(0);
    for (int i = 15; i >= 0; i--) send_bit(16'hC3A5 >> i);
    do_read(5'd2, 5'd9, dm, v, tl);
    chk("R3 start after aborted arm", {16'h0, v}, 32'h0000C3A5);

    // R4: illegal opcodes 1,1 and 0,0 drop the frame
    send_bit(0); send_bit(1); send_bit(1); send_bit(1);
    for (int i = 0; i < 16; i++) send_bit(1);
    send_bit(0); send_bit(1); send_bit(0); send_bit(0);
    do_read(5'd3, 5'd6, dm, v, tl);
    chk("R4 illegal opcode aborts", {16'h0, v}, 32'h00001234);

    // R6: bad turnaround 1,1 drops the write
    send_hdr(1'b1, 5'd3, 5'd6, 0);
    send_bit(1); send_bit(1);
    for (int i = 0; i < 16; i++) send_bit(1);
    do_read(5'd3, 5'd6, dm, v, tl);
    chk("R6 bad turnaround keeps register", {16'h0, v}, 32'h00001234);

    // R2: non-strobe writes inside a frame are stored only
    send_hdr(1'b1, 5'd4, 5'd4, 0);
    ctl_write(WRP | (32'h1 << 15));
    chk("R2 R9 junk word stored", ctl_rdata, WRP | (32'h1 << 15));
    ctl_write((32'h1 << 13) | (32'h1 << 17));
    send_bit(1); send_bit(0);
    for (int i = 15; i >= 0; i--) send_bit(16'h5A5A >> i);
    do_read(5'd4, 5'd4, dm, v, tl);
    chk("R2 junk writes do not advance decoder", {16'h0, v}, 32'h00005A5A);

    // R2: near-miss read strobe does not shift; R9 bit 19 and the rest
    send_hdr(1'b0, 5'd4, 5'd4, 0);
    pop(1'b0, b);
    chk("R9 stored word on pop", ctl_rdata & ~(32'h1 << 19), RDP);
    ctl_write(RDP | (32'h1 << 20));
    chk("R2 near-miss read strobe stored", ctl_rdata, RDP | (32'h1 << 20));
    collect(b, dm, v, tl);
    chk("R2 near-miss read strobe shifts nothing", {16'h0, v}, 32'h00005A5A);

    // R10: read strobe in the cycle right after the last address bit
    send_hdr(1'b0, 5'd31, 5'd31, 1);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = WRP | (32'h1 << 17);
    @(negedge clk); ctl_wdata = RDP;
    @(negedge clk); ctl_we = 1'b0;
    b = ctl_rdata[19];
    collect(b, dm, v, tl);
    chk("R10 coincident load and pop dummy", {31'h0, dm}, 32'h0);
    chk("R10 coincident load and pop value", {16'h0, v}, 32'h00008001);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule